// File: doc/BRIEF.md
# Streaming Segmented Prefix Adder

This block adds two long unsigned integers that arrive in slices of `SEG_W` bits per operand per cycle, lowest slice first. A slice is accepted on every cycle where `in_valid` is high. `in_first` marks the lowest slice of an operand pair and `in_last` marks the highest, so the operand length is the number of slices between the two markers. It is always a whole multiple of `SEG_W`.

Each slice goes through a logarithmic-depth parallel-prefix carry network that finds the slice's local group generate and propagate terms. A single accumulator register holds the combined (generate, propagate) pair of every earlier slice of the current operand. One stage later, that pair is folded into the less significant side of every local prefix term. This gives the true carry into each bit without any ripple between slices, so the adder takes one slice per cycle.

The block emits one sum slice per input slice, with a last flag. On the highest slice it also emits the carry out of the whole operand. When `SEG_W` is 1 the structure reduces to a plain bit-serial carry chain.

Top module: `stream_prefix_adder`

## Requirements
- R1: After reset `out_valid`, `out_last` and `out_cout` are 0. The accumulator holds the neutral pair (generate 0, propagate 1), so a slice sent without `in_first` adds with a carry-in of 0.
- R2: Every accepted slice produces exactly one output slice with `out_valid` high two clock cycles after it was accepted. `out_valid` is low in every other cycle.
- R3: `out_last` equals the `in_last` of the slice being emitted.
- R4: For an operand of one slice (both markers set), `{out_cout, out_sum}` equals the (SEG_W+1)-bit sum of `in_a` and `in_b`.
- R5: For an operand of several slices sent on consecutive cycles, the output slices, joined lowest first, equal the low n bits of A+B.
- R6: A carry made in the lowest slice reaches every higher slice, as in all-ones plus one over eight slices.
- R7: A slice with `in_first` high ignores the accumulated carry of the operand before it, even when that operand follows back to back and ended with a carry out of 1.
- R8: `out_cout` is the carry out of bit n-1 on the highest slice, and is 0 on every other output slice.
- R9: Idle cycles (`in_valid` low) between the slices of one operand leave the accumulated pair unchanged, so the result matches the back-to-back case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input slice present this cycle |
| in_first | input | 1 | Slice is the lowest of its operand |
| in_last | input | 1 | Slice is the highest of its operand |
| in_a | input | SEG_W | Slice of operand A |
| in_b | input | SEG_W | Slice of operand B |
| out_valid | output | 1 | Output slice present this cycle |
| out_last | output | 1 | Output slice is the highest of its operand |
| out_cout | output | 1 | Carry out of the whole operand, set only with out_last |
| out_sum | output | SEG_W | Sum slice |

## Verification
Each result leaves the block two rising edges after its slice was accepted: one edge into the prefix stage register and one into the output register. The bench drives inputs just after a falling edge and samples shortly after the falling edge that follows the second rising edge. A monitor keeps a two-deep history of the `in_valid` value it drove and compares it with `out_valid` every cycle. Every output slice seen is collected, and each scenario task compares the collected slices, last flags and carry out with a wide reference sum once the pipeline has drained.

// File: rtl/spa_pkg.sv
// Shared types for the streaming prefix adder.
// A gp_t is a (generate, propagate) pair; gp_join is the associative carry
// combine with the more significant pair on the left.
package spa_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    localparam gp_t GP_NEUTRAL = '{g: 1'b0, p: 1'b1};

    // Combine a more significant pair with a less significant one.
    function automatic gp_t gp_join(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/spa_pg_gen.sv
// Per-bit generate/propagate formation for one slice.
// Assumes plain unsigned slices; propagate is the XOR of the operand bits.
module spa_pg_gen
    import spa_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output gp_t  [W-1:0] pg
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Form the pair for bit i.
        assign pg[i].g = a[i] & b[i];
        assign pg[i].p = a[i] ^ b[i];
    end

endmodule

// File: rtl/spa_prefix_tree.sv
// Parallel-prefix network over one slice: an up-sweep reduction tree followed by
// a down-sweep that fills in the remaining prefixes.
// Output i is the combined pair of bits i..0 of the slice.
// Assumes W is a power of two; W = 1 gives a straight pass-through.
module spa_prefix_tree
    import spa_pkg::*;
#(
    parameter int W = 16
) (
    input  gp_t [W-1:0] leaf,
    output gp_t [W-1:0] pre
);

    localparam int LOG = $clog2(W);
    localparam int FIN = (LOG == 0) ? 0 : 2 * LOG - 1;

    gp_t [W-1:0] lvl [0:FIN];

    assign lvl[0] = leaf;

    // Up-sweep: level l joins nodes spaced 2**(l-1) apart at every 2**l-th bit.
    for (genvar l = 1; l <= LOG; l++) begin : g_up
        for (genvar i = 0; i < W; i++) begin : g_node
            if (((i + 1) % (1 << l)) == 0) begin : g_join
                assign lvl[l][i] = gp_join(lvl[l-1][i], lvl[l-1][i - (1 << (l-1))]);
            end else begin : g_pass
                assign lvl[l][i] = lvl[l-1][i];
            end
        end
    end

    // Down-sweep: step k fills the midpoints at distance 2**(LOG-k-1).
    for (genvar k = 1; k < LOG; k++) begin : g_dn
        localparam int LV   = LOG - k;
        localparam int DIST = 1 << (LV - 1);
        for (genvar i = 0; i < W; i++) begin : g_node
            if ((((i + 1) % (1 << LV)) == DIST) && (i >= (1 << LV))) begin : g_join
                assign lvl[LOG+k][i] = gp_join(lvl[LOG+k-1][i], lvl[LOG+k-1][i - DIST]);
            end else begin : g_pass
                assign lvl[LOG+k][i] = lvl[LOG+k-1][i];
            end
        end
    end

    assign pre = lvl[FIN];

endmodule

// File: rtl/spa_seg_fix.sv
// Folds the running pair of earlier slices into the local prefixes of the
// current slice and forms the sum bits and the slice's full block pair.
// The seed pair is broadcast to every leaf combine cell.
module spa_seg_fix
    import spa_pkg::*;
#(
    parameter int W = 16
) (
    input  gp_t [W-1:0] loc,
    input  logic [W-1:0] prop,
    input  gp_t          seed,
    output logic [W-1:0] sum,
    output gp_t          blk
);

    logic [W-1:0] cin;

    assign cin[0] = seed.g;

    for (genvar i = 1; i < W; i++) begin : g_cin
        // Carry into bit i: prefix of bits i-1..0 applied onto the seed.
        assign cin[i] = gp_join(loc[i-1], seed).g;
    end

    // Sum bit is propagate XOR incoming carry.
    assign sum = prop ^ cin;

    // Running pair after this slice.
    assign blk = gp_join(loc[W-1], seed);

endmodule

// File: rtl/stream_prefix_adder.sv
// Streaming long-integer adder taking SEG_W bits per operand per cycle, lowest
// slice first. Stage 1 registers the slice's local prefix terms; stage 2 folds
// in the accumulated pair of earlier slices and registers the sum slice.
// Assumes operands are whole multiples of SEG_W and framed by first/last marks.
module stream_prefix_adder
    import spa_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [SEG_W-1:0] in_a,
    input  logic [SEG_W-1:0] in_b,
    output logic             out_valid,
    output logic             out_last,
    output logic             out_cout,
    output logic [SEG_W-1:0] out_sum
);

    gp_t [SEG_W-1:0] leaf_pg;
    gp_t [SEG_W-1:0] loc_pre;
    logic [SEG_W-1:0] leaf_p;

    logic             s1_valid;
    logic             s1_first;
    logic             s1_last;
    gp_t [SEG_W-1:0]  s1_loc;
    logic [SEG_W-1:0] s1_prop;

    gp_t              acc_q;
    gp_t              seed;
    gp_t              blk;
    logic [SEG_W-1:0] fix_sum;

    spa_pg_gen #(.W(SEG_W)) u_pg (
        .a  (in_a),
        .b  (in_b),
        .pg (leaf_pg)
    );

    spa_prefix_tree #(.W(SEG_W)) u_tree (
        .leaf (leaf_pg),
        .pre  (loc_pre)
    );

    for (genvar i = 0; i < SEG_W; i++) begin : g_prop
        // Pull the propagate bits out for the sum stage.
        assign leaf_p[i] = leaf_pg[i].p;
    end

    // Stage 1 register: slice control and local prefix terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_loc   <= '0;
            s1_prop  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_first <= in_first & in_valid;
            s1_last  <= in_last & in_valid;
            s1_loc   <= loc_pre;
            s1_prop  <= leaf_p;
        end
    end

    // A first slice starts from the neutral pair, not the previous operand.
    assign seed = s1_first ? GP_NEUTRAL : acc_q;

    spa_seg_fix #(.W(SEG_W)) u_fix (
        .loc  (s1_loc),
        .prop (s1_prop),
        .seed (seed),
        .sum  (fix_sum),
        .blk  (blk)
    );

    // Accumulator: running pair of all slices of the current operand so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= GP_NEUTRAL;
        end else if (s1_valid) begin
            acc_q <= blk;
        end
    end

    // Output register: sum slice, last flag and operand carry out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_cout  <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_last  <= s1_last;
            out_cout  <= s1_valid & s1_last & blk.g;
            out_sum   <= fix_sum;
        end
    end

endmodule

// File: rtl/spa_checker.sv
// Protocol and arithmetic properties of stream_prefix_adder, bound to it.
module spa_checker
    import spa_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_first,
    input logic         in_last,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic         out_last,
    input logic         out_cout,
    input logic [W-1:0] out_sum,
    input logic         s1_valid,
    input gp_t          acc_q
);

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    assert_idle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    assert_last_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |-> ##2 (out_valid && out_last));

    assert_single_slice_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && in_last) |-> ##2
        ({out_cout, out_sum} == ({1'b0, $past(in_a, 2)} + {1'b0, $past(in_b, 2)})));

    assert_cout_only_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || !out_last) |-> !out_cout);

    assert_acc_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(acc_q));

endmodule

bind stream_prefix_adder spa_checker #(.W(SEG_W)) u_spa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_cout  (out_cout),
    .out_sum   (out_sum),
    .s1_valid  (s1_valid),
    .acc_q     (acc_q)
);

// File: tb/stream_prefix_adder_tb.sv
// Directed bench: each task streams operands, then compares collected output
// slices against a wide reference sum.
module stream_prefix_adder_tb;

    localparam int W    = 16;
    localparam int MAXN = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_first = 1'b0;
    logic         in_last = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic         out_last;
    logic         out_cout;
    logic [W-1:0] out_sum;

    int checks = 0;
    int failures = 0;
    int lat_err = 0;

    logic [W-1:0] cap_sum [0:31];
    logic         cap_last [0:31];
    logic         cap_cout [0:31];
    int           cap_n = 0;
    logic [W-1:0] exp_sum [0:31];
    logic         exp_last [0:31];
    logic         exp_cout [0:31];
    int           exp_n = 0;
    logic         vh1 = 1'b0;
    logic         vh2 = 1'b0;

    stream_prefix_adder #(.SEG_W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_last   (in_last),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_cout  (out_cout),
        .out_sum   (out_sum)
    );

    always #4 clk = ~clk;

    // Monitor: latency against driven in_valid history and slice capture.
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            vh1 = 1'b0;
            vh2 = 1'b0;
        end else begin
            if (out_valid !== vh2) lat_err++;
            if (out_valid === 1'b1 && cap_n < 32) begin
                cap_sum[cap_n]  = out_sum;
                cap_last[cap_n] = out_last;
                cap_cout[cap_n] = out_cout;
                cap_n++;
            end
            vh2 = vh1;
            vh1 = in_valid;
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Stream one operand pair; mark_first=0 omits the first marker.
    task automatic drive_op(input logic [127:0] a_in, input logic [127:0] b_in,
                            input int nseg, input int gap, input bit mark_first);
        logic [127:0] a;
        logic [127:0] b;
        logic [128:0] full;
        a = a_in;
        b = b_in;
        for (int k = nseg * W; k < MAXN; k++) begin
            a[k] = 1'b0;
            b[k] = 1'b0;
        end
        full = {1'b0, a} + {1'b0, b};
        for (int s = 0; s < nseg; s++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = mark_first && (s == 0);
            in_last  = (s == nseg - 1);
            in_a     = a[s*W +: W];
            in_b     = b[s*W +: W];
            exp_sum[exp_n]  = full[s*W +: W];
            exp_last[exp_n] = (s == nseg - 1);
            exp_cout[exp_n] = (s == nseg - 1) ? full[nseg*W] : 1'b0;
            exp_n++;
            if (s < nseg - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_first = 1'b0;
                    in_last  = 1'b0;
                end
            end
        end
    endtask

    // Drain the pipeline and compare collected output with expectations.
    task automatic finish_check(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        check(req, "slice_count", 64'(cap_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(req, "sum", 64'(cap_sum[i]), 64'(exp_sum[i]));
            check("R3", "last", 64'(cap_last[i]), 64'(exp_last[i]));
            check("R8", "cout", 64'(cap_cout[i]), 64'(exp_cout[i]));
        end
        check("R2", "latency_mismatches", 64'(lat_err), 64'd0);
        cap_n = 0;
        exp_n = 0;
        lat_err = 0;
    endtask

    task automatic t_reset_state();
        #2;
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "out_last", 64'(out_last), 64'd0);
        check("R1", "out_cout", 64'(out_cout), 64'd0);
    endtask

    task automatic t_acc_neutral_r1();
        drive_op(128'hFFFF, 128'h0, 1, 0, 1'b0);
        finish_check("R1");
    endtask

    task automatic t_single_r4();
        drive_op(128'hFFFF, 128'h0001, 1, 0, 1'b1);
        finish_check("R4");
        drive_op(rnd128(), rnd128(), 1, 0, 1'b1);
        finish_check("R4");
    endtask

    task automatic t_multi_r5();
        for (int n = 0; n < 3; n++) begin
            drive_op(rnd128(), rnd128(), 4, 0, 1'b1);
            finish_check("R5");
        end
    endtask

    task automatic t_full_chain_r6();
        drive_op({128{1'b1}}, 128'h1, 8, 0, 1'b1);
        finish_check("R6");
    endtask

    task automatic t_first_restart_r7();
        drive_op({128{1'b1}}, 128'h1, 2, 0, 1'b1);
        drive_op(128'h0, 128'h0, 2, 0, 1'b1);
        finish_check("R7");
    endtask

    task automatic t_gaps_r9();
        drive_op({128{1'b1}}, 128'h1, 4, 2, 1'b1);
        finish_check("R9");
        drive_op(rnd128(), rnd128(), 3, 1, 1'b1);
        finish_check("R9");
    endtask

    initial begin : watchdog
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        t_acc_neutral_r1();
        t_single_r4();
        t_multi_r5();
        t_full_chain_r6();
        t_first_restart_r7();
        t_gaps_r9();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule